// File: doc/BRIEF.md
# Branch-Linked Register Region Prefetcher

This block ties every committed branch to the registers that the loads and stores after it use to form their addresses. Commit traffic arrives one instruction per cycle and in program order. A committing branch becomes the current link target. A committing memory instruction adds its address source register to that branch's table entry. Later, a lookahead unit that runs ahead of execution presents branch PCs it predicts the program will reach.

For each lookahead branch that hits in the table, the block reads the present value of every linked register through a register-file read port. It turns each value into the eight 64-byte cache blocks of the 512-byte aligned region that holds it, and streams those block addresses to a prefetch queue. Each entry also has a flag that stops a second burst for the same branch until that branch commits again.

The prefetch output follows valid/ready rules. `pf_valid` and `pf_addr` stay unchanged while `pf_ready` is low, and an address counts as delivered only on a cycle where both are high. The lookahead input follows the same rules: a PC is taken only on a cycle where `la_valid` and `la_ready` are both high. `la_ready` is low while a burst is being walked.

Top module: `regbranch_prefetch`

## Requirements
- R1: After reset, `pf_valid` is 0, `la_ready` is 1, and the table holds no entries, so any lookup yields no addresses.
- R2: A committing branch (`cm_valid`=1, `cm_is_br`=1) becomes the link target. A committing memory instruction (`cm_is_br`=0) adds `cm_src` to the entry of the most recently committed branch only. The entry index is `pc[7:2]` and the tag is `pc[31:8]`.
- R3: An entry holds up to 4 distinct register indices, kept in the order they were first committed. An index already present is not added again. Once 4 are held, further distinct indices are dropped.
- R4: On a hit, each linked register is read at lookup time, so the live value is used. The value V yields the addresses (V with bits 8:0 cleared) + 64·k for k = 0..7, in ascending order.
- R5: A hit yields its regions in slot order, 8 addresses per linked register and no others.
- R6: After a lookup that issued addresses, later lookups of the same branch yield nothing until that branch commits again. A recommit with the same tag keeps the linked registers.
- R7: A committing branch whose index matches but whose tag differs replaces the entry and clears its linked registers. A lookup of the displaced PC then yields nothing.
- R8: A lookup that misses, or that hits an entry with no linked registers, yields no addresses, and `la_ready` is high again in the next cycle.
- R9: While `pf_valid`=1 and `pf_ready`=0, `pf_valid` and `pf_addr` stay unchanged. Under back-pressure no address is lost, repeated or reordered.
- R10: While a burst is walked, `la_ready` is 0 and no new lookahead PC is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cm_valid | input | 1 | A committed instruction is presented this cycle |
| cm_is_br | input | 1 | 1: committed branch, 0: committed memory instruction |
| cm_pc | input | 32 | PC of the committed branch |
| cm_src | input | 5 | Address source register of the committed memory instruction |
| la_valid | input | 1 | Lookahead branch PC is valid |
| la_ready | output | 1 | Block can accept a lookahead PC |
| la_pc | input | 32 | Lookahead branch PC |
| rf_rd_en | output | 1 | Register-file read request |
| rf_rd_idx | output | 5 | Register index to read |
| rf_rd_data | input | 32 | Value of the register at `rf_rd_idx`, same cycle |
| pf_valid | output | 1 | Prefetch block address is valid |
| pf_ready | input | 1 | Prefetch queue accepts the address |
| pf_addr | output | 32 | Cache-block address to prefetch |

## Verification
A corrupted link slot shows up as a region base that matches no linked register. It appears in the first address of that region, two cycles after the lookahead PC is taken. A flag or tag that is stuck high or low turns a whole burst into silence, or silence into a burst, and `la_ready` shows which of the two happened one cycle after acceptance. A wrong block counter or a lost stall shows as a gap, a repeat or an out-of-order address inside an 8-address run, so every address of every burst is compared in order, both with and without back-pressure.

// File: rtl/brpt_pkg.sv
package brpt_pkg;

  typedef enum logic [1:0] {
    WK_IDLE = 2'd0,
    WK_READ = 2'd1,
    WK_EMIT = 2'd2
  } walk_st_t;

endpackage

// File: rtl/brpt_link_table.sv
module brpt_link_table #(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 64,
  parameter int SLOTS   = 4,
  parameter int REG_W   = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cm_valid,
  input  logic                        cm_is_br,
  input  logic [PC_W-1:0]             cm_pc,
  input  logic [REG_W-1:0]            cm_src,
  input  logic [PC_W-1:0]             lk_pc,
  input  logic                        mark_pf,
  output logic                        lk_hit,
  output logic [SLOTS-1:0]            lk_slot_vld,
  output logic [SLOTS-1:0][REG_W-1:0] lk_slot_idx
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - 2 - IDX_W;

  logic                        ent_vld [ENTRIES];
  logic                        ent_pfd [ENTRIES];
  logic [TAG_W-1:0]            ent_tag [ENTRIES];
  logic [SLOTS-1:0]            ent_sv  [ENTRIES];
  logic [SLOTS-1:0][REG_W-1:0] ent_si  [ENTRIES];

  logic             last_vld;
  logic [IDX_W-1:0] last_ix;

  logic [IDX_W-1:0] cm_ix, lk_ix;
  logic [TAG_W-1:0] cm_tag, lk_tag;
  assign cm_ix  = cm_pc[IDX_W+1:2];
  assign cm_tag = cm_pc[PC_W-1:IDX_W+2];
  assign lk_ix  = lk_pc[IDX_W+1:2];
  assign lk_tag = lk_pc[PC_W-1:IDX_W+2];

  logic unused_pc_bits;
  assign unused_pc_bits = ^{cm_pc[1:0], lk_pc[1:0]};

  // slot search for the current link target
  logic [SLOTS-1:0]            m_sv;
  logic [SLOTS-1:0][REG_W-1:0] m_si;
  logic [SLOTS-1:0]            free_oh;
  logic                        dup, have_free, mem_wr, br_wr, tag_eq;

  assign m_sv = ent_sv[last_ix];
  assign m_si = ent_si[last_ix];

  always_comb begin
    dup       = 1'b0;
    have_free = 1'b0;
    free_oh   = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (m_sv[s] && (m_si[s] == cm_src)) dup = 1'b1;
      if (!m_sv[s] && !have_free) begin
        free_oh[s] = 1'b1;
        have_free  = 1'b1;
      end
    end
  end

  assign br_wr  = cm_valid && cm_is_br;
  assign mem_wr = cm_valid && !cm_is_br && last_vld && !dup && have_free;
  assign tag_eq = ent_vld[cm_ix] && (ent_tag[cm_ix] == cm_tag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_vld <= 1'b0;
      last_ix  <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        ent_vld[e] <= 1'b0;
        ent_pfd[e] <= 1'b0;
        ent_tag[e] <= '0;
        ent_sv[e]  <= '0;
        ent_si[e]  <= '0;
      end
    end else begin
      if (mark_pf) ent_pfd[lk_ix] <= 1'b1;
      if (br_wr) begin
        last_vld       <= 1'b1;
        last_ix        <= cm_ix;
        ent_pfd[cm_ix] <= 1'b0;
        if (!tag_eq) begin
          ent_vld[cm_ix] <= 1'b1;
          ent_tag[cm_ix] <= cm_tag;
          ent_sv[cm_ix]  <= '0;
        end
      end
      if (mem_wr) begin
        ent_sv[last_ix] <= m_sv | free_oh;
        for (int s = 0; s < SLOTS; s++)
          if (free_oh[s]) ent_si[last_ix][s] <= cm_src;
      end
    end
  end

  assign lk_slot_vld = ent_sv[lk_ix];
  assign lk_slot_idx = ent_si[lk_ix];
  assign lk_hit      = ent_vld[lk_ix] && (ent_tag[lk_ix] == lk_tag) &&
                       !ent_pfd[lk_ix] && (|ent_sv[lk_ix]);

  generate
    for (genvar gi = 0; gi < SLOTS; gi++) begin : g_pair_a
      for (genvar gj = gi + 1; gj < SLOTS; gj++) begin : g_pair_b
        AST_SLOT_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
          (lk_slot_vld[gi] && lk_slot_vld[gj]) |-> (lk_slot_idx[gi] != lk_slot_idx[gj])); // R3
      end
    end
  endgenerate

  AST_SLOT_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((lk_slot_vld & (lk_slot_vld + SLOTS'(1))) == '0)); // R3

  AST_FLAG_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_pf && !br_wr) |=> (!$stable(lk_pc) || !lk_hit)); // R6

endmodule

// File: rtl/brpt_region_walker.sv
module brpt_region_walker
  import brpt_pkg::*;
#(
  parameter int XLEN         = 32,
  parameter int SLOTS        = 4,
  parameter int REG_W        = 5,
  parameter int REGION_BYTES = 512,
  parameter int BLOCK_BYTES  = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        la_valid,
  output logic                        la_ready,
  input  logic                        lk_hit,
  input  logic [SLOTS-1:0]            lk_slot_vld,
  input  logic [SLOTS-1:0][REG_W-1:0] lk_slot_idx,
  output logic                        mark_pf,
  output logic                        rf_rd_en,
  output logic [REG_W-1:0]            rf_rd_idx,
  input  logic [XLEN-1:0]             rf_rd_data,
  output logic                        pf_valid,
  input  logic                        pf_ready,
  output logic [XLEN-1:0]             pf_addr
);

  localparam int REG_SH = $clog2(REGION_BYTES);
  localparam int BLK_SH = $clog2(BLOCK_BYTES);
  localparam int BLOCKS = REGION_BYTES / BLOCK_BYTES;
  localparam int CNT_W  = (BLOCKS > 1) ? $clog2(BLOCKS) : 1;

  walk_st_t                    st;
  logic [SLOTS-1:0]            pend;
  logic [SLOTS-1:0][REG_W-1:0] sidx;
  logic [XLEN-1:0]             base;
  logic [CNT_W-1:0]            blk;

  logic [SLOTS-1:0] cur_oh;
  logic [REG_W-1:0] cur_idx;
  logic             picked, accept, last_blk;

  always_comb begin
    cur_oh  = '0;
    cur_idx = '0;
    picked  = 1'b0;
    for (int s = 0; s < SLOTS; s++) begin
      if (pend[s] && !picked) begin
        cur_oh[s] = 1'b1;
        cur_idx   = sidx[s];
        picked    = 1'b1;
      end
    end
  end

  logic unused_low;
  assign unused_low = ^rf_rd_data[REG_SH-1:0];

  assign la_ready  = (st == WK_IDLE);
  assign accept    = la_valid && la_ready;
  assign mark_pf   = accept && lk_hit;
  assign rf_rd_en  = (st == WK_READ);
  assign rf_rd_idx = cur_idx;
  assign pf_valid  = (st == WK_EMIT);
  assign pf_addr   = base + (XLEN'(blk) << BLK_SH);
  assign last_blk  = (blk == CNT_W'(BLOCKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= WK_IDLE;
      pend <= '0;
      sidx <= '0;
      base <= '0;
      blk  <= '0;
    end else begin
      unique case (st)
        WK_IDLE: if (mark_pf) begin
          pend <= lk_slot_vld;
          sidx <= lk_slot_idx;
          st   <= WK_READ;
        end
        WK_READ: begin
          base <= {rf_rd_data[XLEN-1:REG_SH], {REG_SH{1'b0}}};
          pend <= pend & ~cur_oh;
          blk  <= '0;
          st   <= WK_EMIT;
        end
        WK_EMIT: if (pf_ready) begin
          if (last_blk) st <= (|pend) ? WK_READ : WK_IDLE;
          else          blk <= blk + CNT_W'(1);
        end
        default: st <= WK_IDLE;
      endcase
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr))); // R9

  AST_REGION_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && pf_ready && !last_blk) |=>
      (pf_valid && (pf_addr == $past(pf_addr) + XLEN'(BLOCK_BYTES)))); // R4

  AST_READ_THEN_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rf_rd_en |=> (pf_valid && (pf_addr[REG_SH-1:0] == '0))); // R4

  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> !la_ready); // R10

  AST_EMPTY_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (la_valid && la_ready && !lk_hit) |=> la_ready); // R8

endmodule

// File: rtl/regbranch_prefetch.sv
module regbranch_prefetch #(
  parameter int PC_W         = 32,
  parameter int XLEN         = 32,
  parameter int ENTRIES      = 64,
  parameter int SLOTS        = 4,
  parameter int REG_W        = 5,
  parameter int REGION_BYTES = 512,
  parameter int BLOCK_BYTES  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cm_valid,
  input  logic             cm_is_br,
  input  logic [PC_W-1:0]  cm_pc,
  input  logic [REG_W-1:0] cm_src,
  input  logic             la_valid,
  output logic             la_ready,
  input  logic [PC_W-1:0]  la_pc,
  output logic             rf_rd_en,
  output logic [REG_W-1:0] rf_rd_idx,
  input  logic [XLEN-1:0]  rf_rd_data,
  output logic             pf_valid,
  input  logic             pf_ready,
  output logic [XLEN-1:0]  pf_addr
);

  logic                        lk_hit, mark_pf;
  logic [SLOTS-1:0]            lk_slot_vld;
  logic [SLOTS-1:0][REG_W-1:0] lk_slot_idx;

  brpt_link_table #(
    .PC_W(PC_W), .ENTRIES(ENTRIES), .SLOTS(SLOTS), .REG_W(REG_W)
  ) i_table (
    .clk(clk), .rst_n(rst_n),
    .cm_valid(cm_valid), .cm_is_br(cm_is_br), .cm_pc(cm_pc), .cm_src(cm_src),
    .lk_pc(la_pc), .mark_pf(mark_pf),
    .lk_hit(lk_hit), .lk_slot_vld(lk_slot_vld), .lk_slot_idx(lk_slot_idx)
  );

  brpt_region_walker #(
    .XLEN(XLEN), .SLOTS(SLOTS), .REG_W(REG_W),
    .REGION_BYTES(REGION_BYTES), .BLOCK_BYTES(BLOCK_BYTES)
  ) i_walker (
    .clk(clk), .rst_n(rst_n),
    .la_valid(la_valid), .la_ready(la_ready),
    .lk_hit(lk_hit), .lk_slot_vld(lk_slot_vld), .lk_slot_idx(lk_slot_idx),
    .mark_pf(mark_pf),
    .rf_rd_en(rf_rd_en), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
  );

endmodule

// File: tb/test_regbranch_prefetch.sv
`timescale 1ns/1ps
module test_regbranch_prefetch;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cm_valid = 1'b0, cm_is_br = 1'b0;
  logic [31:0] cm_pc = '0;
  logic [4:0]  cm_src = '0;
  logic        la_valid = 1'b0;
  logic [31:0] la_pc = '0;
  logic        la_ready, rf_rd_en, pf_valid;
  logic [4:0]  rf_rd_idx;
  logic [31:0] rf_rd_data, pf_addr;
  logic        pf_ready = 1'b1;

  logic [31:0] rf [32];
  assign rf_rd_data = rf[rf_rd_idx];

  always #2 clk = ~clk;

  regbranch_prefetch i_regbranch_prefetch (
    .clk(clk), .rst_n(rst_n),
    .cm_valid(cm_valid), .cm_is_br(cm_is_br), .cm_pc(cm_pc), .cm_src(cm_src),
    .la_valid(la_valid), .la_ready(la_ready), .la_pc(la_pc),
    .rf_rd_en(rf_rd_en), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
  );

  int n_checks = 0;
  int n_err    = 0;

  // capture of delivered addresses (single writer)
  logic [31:0] cap [1024];
  int          ncap = 0;
  always @(negedge clk)
    if (pf_valid && pf_ready && ncap < 1024) begin
      cap[ncap] = pf_addr;
      ncap++;
    end

  // back-pressure pattern, changed just after the rising edge
  bit stall_mode = 1'b0;
  int rdy_cnt = 0;
  always @(posedge clk) begin
    #1;
    rdy_cnt++;
    pf_ready = stall_mode ? ((rdy_cnt % 3) != 0) : 1'b1;
  end

  logic [31:0] expv [64];
  int          nexp;
  int          start;
  bit          first_ready;

  localparam int NVEC = 4;
  localparam logic [31:0] V_PC  [NVEC] = '{32'h0000_1004, 32'h0000_2010,
                                           32'h0040_0020, 32'h0000_30FC};
  localparam int          V_N   [NVEC] = '{2, 3, 6, 1};
  localparam logic [29:0] V_SRC [NVEC] = '{
    {5'd0, 5'd0, 5'd0, 5'd0, 5'd7, 5'd3},
    {5'd0, 5'd0, 5'd0, 5'd9, 5'd5, 5'd5},
    {5'd2, 5'd6, 5'd4, 5'd3, 5'd2, 5'd1},
    {25'd0, 5'd31}};

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
  endtask

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic commit_br(input logic [31:0] pc);
    cm_valid = 1'b1; cm_is_br = 1'b1; cm_pc = pc;
    @(negedge clk);
    cm_valid = 1'b0; cm_is_br = 1'b0;
  endtask

  task automatic commit_mem(input logic [4:0] src);
    cm_valid = 1'b1; cm_is_br = 1'b0; cm_src = src;
    @(negedge clk);
    cm_valid = 1'b0;
  endtask

  task automatic add_region(input logic [4:0] r);
    logic [31:0] b;
    b = rf[r] & ~32'h1FF;
    for (int k = 0; k < 8; k++) begin
      expv[nexp] = b + 32'(k * 64);
      nexp++;
    end
  endtask

  task automatic do_lookup(input logic [31:0] pc);
    int w;
    start = ncap;
    la_valid = 1'b1; la_pc = pc;
    @(negedge clk);
    la_valid = 1'b0;
    first_ready = la_ready;
    w = 0;
    while (!la_ready && w < 1000) begin
      @(negedge clk);
      w++;
    end
  endtask

  task automatic compare_run(input string req);
    int got;
    got = ncap - start;
    check(got == nexp, {req, " R5 count"}, 32'(got), 32'(nexp));
    for (int i = 0; i < nexp; i++)
      if (i < got) check(cap[start + i] == expv[i], req, cap[start + i], expv[i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++; n_checks++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    report();
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = 32'h0800_0000 + 32'(i) * 32'h0002_4680;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(pf_valid == 1'b0, "R1 pf_valid", {31'd0, pf_valid}, 32'd0);
    check(la_ready == 1'b1, "R1 la_ready", {31'd0, la_ready}, 32'd1);
    nexp = 0;
    do_lookup(V_PC[0]);
    compare_run("R1 empty table");

    // vector table: link, refresh live values, look up, compare
    for (int v = 0; v < NVEC; v++) begin
      logic [4:0] lst [4];
      int nl;
      nl = 0;
      commit_br(V_PC[v]);
      for (int k = 0; k < V_N[v]; k++) begin
        logic [4:0] s;
        bit seen;
        s = V_SRC[v][5*k +: 5];
        commit_mem(s);
        seen = 1'b0;
        for (int j = 0; j < nl; j++) if (lst[j] == s) seen = 1'b1;
        if (!seen && nl < 4) begin lst[nl] = s; nl++; end
        rf[s] = (s == 5'd31) ? 32'hFFFF_FFF0
              : 32'h1000_0000 + 32'(s) * 32'h0013_5793 + 32'(v) * 32'h0100_0000;
      end
      nexp = 0;
      for (int j = 0; j < nl; j++) add_region(lst[j]);
      do_lookup(V_PC[v]);
      compare_run((v == 2) ? "R3 dedup/cap" : "R4 region");
    end

    // R6: flag blocks a second burst
    nexp = 0;
    do_lookup(V_PC[0]);
    compare_run("R6 flag set");

    // R6 + R4: recommit same tag keeps slots, new live values used
    commit_br(V_PC[0]);
    rf[3] = 32'h7654_3ABC;
    rf[7] = 32'h0000_01FF;
    nexp = 0; add_region(5'd3); add_region(5'd7);
    do_lookup(V_PC[0]);
    compare_run("R6 recommit");

    // R7: replacement by same index, different tag
    commit_br(32'h0000_2010);
    commit_br(32'h0000_5010);
    commit_mem(5'd12);
    nexp = 0;
    do_lookup(32'h0000_2010);
    compare_run("R7 displaced");
    nexp = 0; add_region(5'd12);
    do_lookup(32'h0000_5010);
    compare_run("R7 cleared slots");

    // R8: entry with no linked registers
    commit_br(32'h0000_6024);
    commit_br(32'h0000_7028);
    nexp = 0;
    do_lookup(32'h0000_6024);
    compare_run("R8 no slots");
    check(first_ready == 1'b1, "R8 ready next cycle", {31'd0, first_ready}, 32'd1);

    // R2: memory links go to the most recent branch only
    commit_br(32'h0000_8030);
    commit_mem(5'd20);
    commit_br(32'h0000_8034);
    commit_mem(5'd21);
    nexp = 0; add_region(5'd20);
    do_lookup(32'h0000_8030);
    compare_run("R2 first branch");
    nexp = 0; add_region(5'd21);
    do_lookup(32'h0000_8034);
    compare_run("R2 second branch");

    // R9 / R10: back-pressure on a four-region burst
    commit_br(V_PC[2]);
    for (int r = 1; r <= 4; r++) rf[r] = 32'h2000_0000 + 32'(r) * 32'h0000_0A40;
    stall_mode = 1'b1;
    nexp = 0;
    for (int r = 1; r <= 4; r++) add_region(5'(r));
    do_lookup(V_PC[2]);
    check(first_ready == 1'b0, "R10 busy", {31'd0, first_ready}, 32'd0);
    compare_run("R9 stall order");
    stall_mode = 1'b0;

    report();
    $finish;
  end

endmodule